// File: doc/BRIEF.md
# Multi-Frequency Tone-Pair Qualification Timer

This block sits behind six per-channel tone detectors in a multi-frequency signalling receiver. It samples their six presence flags once per frame. A frame is about 2.3 ms long and its tick comes from a built-in clock divider. The block measures how long each flag pattern stays unchanged. A pattern with exactly two channels set is a tone pair. A pair that has lasted long enough is published as a qualified 6-bit pattern with a valid flag. A run of silence that has lasted long enough counts as an inter-digit pause and clears the output. A malformed pattern that persists raises an error flag.

All durations are counted in whole frames. The pair on channels 2 and 5 is the key-pulse pair. When the `long_kp` input is high, that pair needs a longer detect time. A pair is reported once. The same pair is not reported again until a pause has been qualified. Short drop-outs and short onset skew between the two tones are tolerated.

Top module: `tone_pair_qual`

## Requirements
- R1: `frame_tick` is high for one clock in every `CLK_DIV` clocks. The outputs `pair_out`, `pair_valid` and `pair_error` change only on a clock edge where `frame_tick` is high.
- R2: When `pair_valid` is 1, `pair_out` has exactly two bits set, and bit n stands for channel n. When `pair_valid` is 0, `pair_out` is zero.
- R3: A two-bit pattern that is unchanged for `DET_FRAMES` consecutive ticks (default 13) is accepted. On the tick that completes the count, `pair_out` takes the pattern and `pair_valid` goes to 1. The same pattern held for fewer ticks is not accepted.
- R4: The key-pulse pattern is 6'b100100, meaning channels 2 and 5. With `long_kp` = 1 it needs `KP_DET_FRAMES` ticks (default 24). With `long_kp` = 0 it needs `DET_FRAMES`, the same as any other pair.
- R5: Any change of the sampled pattern restarts the duration count at 1. While a new pattern is still being timed, the previously qualified outputs are held.
- R6: An all-zero pattern held for `PAUSE_FRAMES` ticks (default 9) is a qualified pause. It clears `pair_out`, `pair_valid` and `pair_error`. A shorter gap leaves the current detect in place.
- R7: A nonzero pattern that does not have exactly two bits set raises `pair_error` once it has been held for `ERR_FRAMES` ticks (default 3). At the same time it clears `pair_valid` and `pair_out`. A shorter run, such as onset skew of up to two frames, raises no error.
- R8: After a pair is accepted, that same pair is not accepted again until a pause has been qualified. A different pair can be accepted without a pause.
- R9: `pair_valid` and `pair_error` are never 1 at the same time.
- R10: A synchronous active-high `rst` clears the outputs, the duration count and the frame divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_flags | input | 6 | Per-channel tone-present flags; bit n is channel n |
| long_kp | input | 1 | Selects the longer detect time for the key-pulse pair |
| frame_tick | output | 1 | One-clock frame strobe; flags are sampled on this edge |
| pair_out | output | 6 | Qualified pattern, one bit per channel |
| pair_valid | output | 1 | A qualified pair is present on `pair_out` |
| pair_error | output | 1 | A persistent malformed pattern was seen |

## Verification
Every result comes from a register that loads on the clock edge where `frame_tick` is high. A pattern's effect is therefore due on the edge that consumes its N-th frame tick: N = `DET_FRAMES`, `KP_DET_FRAMES`, `PAUSE_FRAMES` or `ERR_FRAMES`, depending on the kind of pattern. The bench holds each stimulus across a whole number of ticks. It waits for the falling edge at which `frame_tick` is high, lets the next rising edge consume the frame, and samples one falling edge later. Each check is therefore taken exactly after the tick that should, or should not, have changed the outputs.

// File: rtl/tq_pkg.sv
package tq_pkg;

  localparam int NCH = 6;
  localparam logic [NCH-1:0] KP_PATTERN = 6'b100100;

  function automatic int unsigned ones6(input logic [NCH-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NCH; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic is_pair(input logic [NCH-1:0] v);
    return ones6(v) == 2;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tq_frame_div.sv
module tq_frame_div #(
  parameter int CLK_DIV = 287500
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tq_run_tracker.sv
module tq_run_tracker #(
  parameter int NCH = 6,
  parameter int MAX_RUN = 24,
  localparam int CW = $clog2(MAX_RUN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NCH-1:0] pat,
  output logic [CW-1:0]  run_next
);
  localparam logic [CW-1:0] SAT = CW'(MAX_RUN);

  logic [NCH-1:0] prev_pat;
  logic [CW-1:0]  run;
  logic           same;

  assign same = (pat == prev_pat);

  always_comb begin
    if (!same)           run_next = CW'(1);
    else if (run == SAT) run_next = run;
    else                 run_next = run + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_pat <= '0;
      run      <= '0;
    end else if (tick) begin
      prev_pat <= pat;
      run      <= run_next;
    end
  end
endmodule

// File: rtl/tq_decider.sv
module tq_decider
  import tq_pkg::*;
#(
  parameter int DET_FRAMES    = 13,
  parameter int KP_DET_FRAMES = 24,
  parameter int PAUSE_FRAMES  = 9,
  parameter int ERR_FRAMES    = 3,
  parameter int CW            = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [NCH-1:0] pat,
  input  logic           long_kp,
  input  logic [CW-1:0]  run_next,
  output logic           ev_accept,
  output logic           ev_pause,
  output logic           ev_error,
  output logic [NCH-1:0] out_pat,
  output logic           valid,
  output logic           err
);
  localparam logic [CW-1:0] T_DET   = CW'(DET_FRAMES);
  localparam logic [CW-1:0] T_KP    = CW'(KP_DET_FRAMES);
  localparam logic [CW-1:0] T_PAUSE = CW'(PAUSE_FRAMES);
  localparam logic [CW-1:0] T_ERR   = CW'(ERR_FRAMES);

  logic [NCH-1:0] last_pair;
  logic           pat_zero, pat_pair, pat_bad;
  logic [CW-1:0]  need;

  assign pat_zero = (pat == '0);
  assign pat_pair = is_pair(pat);
  assign pat_bad  = !pat_zero && !pat_pair;
  assign need     = (long_kp && pat == KP_PATTERN) ? T_KP : T_DET;

  assign ev_pause  = tick && pat_zero && (run_next >= T_PAUSE);
  assign ev_accept = tick && pat_pair && (run_next >= need) && (pat != last_pair);
  assign ev_error  = tick && pat_bad && (run_next >= T_ERR);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pair <= '0;
      out_pat   <= '0;
      valid     <= 1'b0;
      err       <= 1'b0;
    end else if (ev_pause) begin
      last_pair <= '0;
      out_pat   <= '0;
      valid     <= 1'b0;
      err       <= 1'b0;
    end else if (ev_accept) begin
      last_pair <= pat;
      out_pat   <= pat;
      valid     <= 1'b1;
      err       <= 1'b0;
    end else if (ev_error) begin
      out_pat   <= '0;
      valid     <= 1'b0;
      err       <= 1'b1;
    end
  end
endmodule

// File: rtl/tone_pair_qual.sv
module tone_pair_qual
  import tq_pkg::*;
#(
  parameter int CLK_DIV       = 287500,
  parameter int DET_FRAMES    = 13,
  parameter int KP_DET_FRAMES = 24,
  parameter int PAUSE_FRAMES  = 9,
  parameter int ERR_FRAMES    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] tone_flags,
  input  logic       long_kp,
  output logic       frame_tick,
  output logic [5:0] pair_out,
  output logic       pair_valid,
  output logic       pair_error
);
  localparam int MAX_RUN = max2(max2(DET_FRAMES, KP_DET_FRAMES),
                                max2(PAUSE_FRAMES, ERR_FRAMES));
  localparam int CW = $clog2(MAX_RUN + 1);

  logic [CW-1:0] run_next;
  logic          ev_accept, ev_pause, ev_error;

  tq_frame_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst(rst), .tick(frame_tick)
  );

  tq_run_tracker #(.NCH(NCH), .MAX_RUN(MAX_RUN)) u_run (
    .clk(clk), .rst(rst), .tick(frame_tick), .pat(tone_flags),
    .run_next(run_next)
  );

  tq_decider #(
    .DET_FRAMES(DET_FRAMES), .KP_DET_FRAMES(KP_DET_FRAMES),
    .PAUSE_FRAMES(PAUSE_FRAMES), .ERR_FRAMES(ERR_FRAMES), .CW(CW)
  ) u_dec (
    .clk(clk), .rst(rst), .tick(frame_tick), .pat(tone_flags),
    .long_kp(long_kp), .run_next(run_next),
    .ev_accept(ev_accept), .ev_pause(ev_pause), .ev_error(ev_error),
    .out_pat(pair_out), .valid(pair_valid), .err(pair_error)
  );
endmodule

// File: rtl/tone_pair_qual_chk.sv
module tone_pair_qual_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [5:0] out_pat,
  input logic       valid,
  input logic       err,
  input logic       ev_accept,
  input logic       ev_pause
);
  // R9
  never_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid && err));

  // R2
  pair_shape_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($countones(out_pat) == 2));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (out_pat == 6'b0));

  // R1
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(out_pat) && $stable(valid) && $stable(err)));

  // R3
  accept_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ev_accept |=> valid);

  // R6
  pause_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ev_pause |=> (!valid && !err && out_pat == 6'b0));
endmodule

bind tone_pair_qual tone_pair_qual_chk u_chk (
  .clk(clk), .rst(rst), .tick(frame_tick), .out_pat(pair_out),
  .valid(pair_valid), .err(pair_error), .ev_accept(ev_accept),
  .ev_pause(ev_pause)
);

// File: tb/tone_pair_qual_bench.sv
module tone_pair_qual_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] tone_flags = '0;
  logic       long_kp = 1'b0;
  logic       frame_tick;
  logic [5:0] pair_out;
  logic       pair_valid, pair_error;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tone_pair_qual #(.CLK_DIV(DIV)) u_tone_pair_qual (
    .clk(clk), .rst(rst), .tone_flags(tone_flags), .long_kp(long_kp),
    .frame_tick(frame_tick), .pair_out(pair_out),
    .pair_valid(pair_valid), .pair_error(pair_error)
  );

  // fields: pattern[22:17] frames[16:9] long_kp[8] exp_out[7:2] exp_valid[1] exp_err[0]
  localparam int NV = 22;
  localparam logic [22:0] VEC [NV] = '{
    {6'b000000, 8'd10, 1'b0, 6'b000000, 1'b0, 1'b0}, // R6 idle
    {6'b000011, 8'd12, 1'b0, 6'b000000, 1'b0, 1'b0}, // R3 too short
    {6'b000011, 8'd1,  1'b0, 6'b000011, 1'b1, 1'b0}, // R3 accepted on 13th
    {6'b000000, 8'd8,  1'b0, 6'b000011, 1'b1, 1'b0}, // R6 short break kept
    {6'b000011, 8'd13, 1'b0, 6'b000011, 1'b1, 1'b0}, // R8 no re-report
    {6'b000000, 8'd9,  1'b0, 6'b000000, 1'b0, 1'b0}, // R6 pause clears
    {6'b000001, 8'd2,  1'b0, 6'b000000, 1'b0, 1'b0}, // R7 skew tolerated
    {6'b000101, 8'd13, 1'b0, 6'b000101, 1'b1, 1'b0}, // R5 count restarts
    {6'b000111, 8'd2,  1'b0, 6'b000101, 1'b1, 1'b0}, // R5 hold while timing
    {6'b000111, 8'd1,  1'b0, 6'b000000, 1'b0, 1'b1}, // R7 error raised
    {6'b000101, 8'd13, 1'b0, 6'b000000, 1'b0, 1'b1}, // R8 same pair blocked
    {6'b000000, 8'd9,  1'b0, 6'b000000, 1'b0, 1'b0}, // R6 clears error
    {6'b100100, 8'd13, 1'b0, 6'b100100, 1'b1, 1'b0}, // R4 kp normal timing
    {6'b000000, 8'd9,  1'b0, 6'b000000, 1'b0, 1'b0}, // R6
    {6'b100100, 8'd23, 1'b1, 6'b000000, 1'b0, 1'b0}, // R4 long kp too short
    {6'b100100, 8'd1,  1'b1, 6'b100100, 1'b1, 1'b0}, // R4 long kp accepted
    {6'b000000, 8'd9,  1'b1, 6'b000000, 1'b0, 1'b0}, // R6
    {6'b110000, 8'd13, 1'b1, 6'b110000, 1'b1, 1'b0}, // R4 other pair unaffected
    {6'b000110, 8'd13, 1'b0, 6'b000110, 1'b1, 1'b0}, // R8 different pair
    {6'b000000, 8'd9,  1'b0, 6'b000000, 1'b0, 1'b0}, // R6
    {6'b001000, 8'd3,  1'b0, 6'b000000, 1'b0, 1'b1}, // R7 single tone error
    {6'b000000, 8'd9,  1'b0, 6'b000000, 1'b0, 1'b0}  // R9 both low
  };
  localparam int REQ [NV] = '{6,3,3,6,8,6,7,5,5,7,8,6,4,6,4,4,6,4,8,6,7,9};

  task automatic check(input int req, input string what,
                       input logic [5:0] ep, input logic ev, input logic ee);
    compared++;
    if (pair_out !== ep || pair_valid !== ev || pair_error !== ee) begin
      mismatched++;
      $display("FAIL R%0d %s: got out=%b v=%b e=%b, expected out=%b v=%b e=%b",
               req, what, pair_out, pair_valid, pair_error, ep, ev, ee);
    end
  endtask

  // hold pattern p across one frame tick; returns at the negedge after the consuming edge
  task automatic frame(input logic [5:0] p);
    tone_flags = p;
    while (!frame_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(10, "reset state", 6'b0, 1'b0, 1'b0);

    // R1 tick period
    begin
      int gap;
      while (!frame_tick) @(negedge clk);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!frame_tick);
      compared++;
      if (gap != DIV) begin
        mismatched++;
        $display("FAIL R1 tick period: got %0d, expected %0d", gap, DIV);
      end
    end

    for (int i = 0; i < NV; i++) begin
      long_kp = VEC[i][8];
      for (int k = 0; k < int'(VEC[i][16:9]); k++) frame(VEC[i][22:17]);
      check(REQ[i], $sformatf("vector %0d", i), VEC[i][7:2], VEC[i][1], VEC[i][0]);
    end

    // R10 reset mid-run restarts the count
    long_kp = 1'b0;
    for (int k = 0; k < 12; k++) frame(6'b001001);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(10, "after mid-run reset", 6'b0, 1'b0, 1'b0);
    frame(6'b001001);
    check(10, "count cleared by reset", 6'b0, 1'b0, 1'b0);
    for (int k = 0; k < 11; k++) frame(6'b001001);
    check(3, "12 frames after reset", 6'b0, 1'b0, 1'b0);
    frame(6'b001001);
    check(3, "13th frame after reset", 6'b001001, 1'b1, 1'b0);

    done = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
    end
  end
endmodule